// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block is a small fully associative translation cache that sits between an address generator and the page-table walker. Every entry holds a virtual page number, the frame number it maps to, the address-space identifier of the process that installed it, a valid flag and a wired flag. A lookup compares the presented page number against all entries at once and, in the same cycle, reports a hit with the frame number or reports a miss. With identifier checking enabled, an entry only hits when its stored identifier equals the identifier of the running process. This lets mappings from several processes live side by side.

After a miss, the walker returns the page/frame pair through the refill port. The entry that receives it is chosen in a fixed order. First comes an entry that already holds the same key. Next is the lowest-numbered empty entry. Last is the least recently used entry that is not wired. Wired entries, such as kernel mappings, are never evicted and survive a flush. A flush request clears every other entry. When identifier checking is off, a change of the current identifier flushes on its own, because stale mappings from the previous process would otherwise hit.

The refill port follows valid/ready rules. A refill is taken on a clock edge where `fill_valid` and `fill_ready` are both high. `fill_ready` drops only in a cycle that flushes. In that cycle a held refill is simply not taken, and the sender keeps it until ready returns. Lookups are combinational and have no back-pressure.

Top module: `tlb_asid_cache`

## Requirements
- R1: After reset every entry is invalid: any lookup reports a miss with `lkp_pfn` = 0, `fill_ready` is 1 and `fill_err` is 0.
- R2: With `lkp_valid` high, `lkp_hit` rises in the same cycle when some valid entry holds `lkp_vpn` and either `asid_en` is 0 or its stored identifier equals `cur_asid`. `lkp_pfn` then carries that entry's frame, taken from the lowest index if several match. Otherwise `lkp_miss` is high and `lkp_pfn` is 0. Both flags are 0 while `lkp_valid` is low.
- R3: With `asid_en` = 1, an entry whose page matches but whose stored identifier differs from `cur_asid` gives a miss. A refill of the same page under another identifier creates a second entry, and both entries stay usable.
- R4: An accepted refill is stored with the current `cur_asid` and can be seen by a lookup from the next cycle on. If an entry already matches the refill key, that entry is overwritten. Otherwise the lowest-index invalid entry is used.
- R5: When every entry is valid and none matches, a refill replaces the non-wired entry whose last use is oldest. A use is a hit or a refill of that entry. When a refill is written in the same cycle as a hit, only the refill counts as a use.
- R6: An entry written with `fill_wired` = 1 is never chosen for replacement, and a flush does not clear it.
- R7: `flush` = 1 clears all non-wired entries at the next edge. `fill_ready` is 0 in that cycle, so no refill is taken then.
- R8: With `asid_en` = 0, a cycle whose `cur_asid` differs from its value in the previous cycle flushes exactly as R7. The identifier held since reset starts at 0.
- R9: A refill offered while every entry is valid and wired, with no matching entry, is dropped. `fill_err` is 1 in that cycle and no entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| asid_en | input | 1 | 1: identifiers take part in matching |
| cur_asid | input | ASID_W (8) | Identifier of the running process |
| flush | input | 1 | Clear all non-wired entries |
| lkp_valid | input | 1 | Lookup request |
| lkp_vpn | input | VPN_W (20) | Virtual page to translate |
| lkp_hit | output | 1 | Lookup found a mapping |
| lkp_miss | output | 1 | Lookup found no mapping |
| lkp_pfn | output | PFN_W (16) | Frame number on hit, else 0 |
| fill_valid | input | 1 | Refill offered |
| fill_ready | output | 1 | Refill can be taken this cycle |
| fill_vpn | input | VPN_W (20) | Refill page number |
| fill_pfn | input | PFN_W (16) | Refill frame number |
| fill_wired | input | 1 | Mark refilled entry as not replaceable |
| fill_err | output | 1 | Accepted refill dropped: all entries wired |

## Verification
Some properties are checked by assertions on every cycle. The recency ages always form a permutation. An eviction never targets a wired or invalid entry. A flush leaves no non-wired entry valid. A written refill can be found at its slot in the next cycle. The bench's reference model keeps per-entry time stamps, and only the bench's scenarios can show the rest. That covers the exact eviction order after mixed hits and refills, the split of entries by identifier, the automatic flush when identifier checking is off, and the refill dropped when every entry is wired.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_MATCH = 2'd1,
    SRC_FREE  = 2'd2,
    SRC_EVICT = 2'd3
  } fill_src_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int DEPTH  = 16,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic [DEPTH-1:0]  ent_valid,
  input  logic [VPN_W-1:0]  ent_vpn  [DEPTH],
  input  logic [ASID_W-1:0] ent_asid [DEPTH],
  input  logic [VPN_W-1:0]  key_vpn,
  input  logic [ASID_W-1:0] key_asid,
  input  logic              asid_chk,
  output logic [DEPTH-1:0]  match
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = ent_valid[g] && (ent_vpn[g] == key_vpn) &&
                      (!asid_chk || (ent_asid[g] == key_asid));
  end
endmodule

// File: rtl/tlb_prio.sv
module tlb_prio #(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic [DEPTH-1:0] cand,
  output logic             victim_found,
  output logic [IDX_W-1:0] victim_idx
);
  logic [IDX_W-1:0] age [DEPTH];
  logic [IDX_W-1:0] best;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) age[i] <= IDX_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (IDX_W'(i) == touch_idx)       age[i] <= '0;
        else if (age[i] < age[touch_idx]) age[i] <= age[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_found = 1'b0;
    victim_idx   = '0;
    best         = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cand[i] && (!victim_found || age[i] > best)) begin
        victim_found = 1'b1;
        victim_idx   = IDX_W'(i);
        best         = age[i];
      end
    end
  end

  // R5: ages stay a permutation, so recency order is total
  for (genvar v = 0; v < DEPTH; v++) begin : g_age_chk
    logic [DEPTH-1:0] holds_v;
    for (genvar e = 0; e < DEPTH; e++) begin : g_e
      assign holds_v[e] = (age[e] == IDX_W'(v));
    end
    a_r5_age_unique: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(holds_v));
  end
endmodule

// File: rtl/tlb_asid_cache.sv
module tlb_asid_cache
  import tlb_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 16,
  parameter int ASID_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              asid_en,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              flush,
  input  logic              lkp_valid,
  input  logic [VPN_W-1:0]  lkp_vpn,
  output logic              lkp_hit,
  output logic              lkp_miss,
  output logic [PFN_W-1:0]  lkp_pfn,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic              fill_wired,
  output logic              fill_err
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DEPTH-1:0]  valid_q, wired_q;
  logic [VPN_W-1:0]  vpn_q  [DEPTH];
  logic [ASID_W-1:0] asid_q [DEPTH];
  logic [PFN_W-1:0]  pfn_q  [DEPTH];
  logic [ASID_W-1:0] prev_asid_q;

  logic [DEPTH-1:0] hit_vec, fm_vec;
  logic             hit_any, fm_any, free_any, vic_any;
  logic [IDX_W-1:0] hit_idx, fm_idx, free_idx, vic_idx, tgt_idx, touch_idx;
  fill_src_e        src;
  logic             flush_now, fill_acc, fill_wr, touch_en;

  tlb_cam #(.DEPTH(DEPTH), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_cam_lkp (
    .ent_valid(valid_q), .ent_vpn(vpn_q), .ent_asid(asid_q),
    .key_vpn(lkp_vpn), .key_asid(cur_asid), .asid_chk(asid_en), .match(hit_vec));

  tlb_cam #(.DEPTH(DEPTH), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_cam_fill (
    .ent_valid(valid_q), .ent_vpn(vpn_q), .ent_asid(asid_q),
    .key_vpn(fill_vpn), .key_asid(cur_asid), .asid_chk(asid_en), .match(fm_vec));

  tlb_prio #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pr_hit (
    .req(hit_vec), .found(hit_any), .idx(hit_idx));
  tlb_prio #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pr_fm (
    .req(fm_vec), .found(fm_any), .idx(fm_idx));
  tlb_prio #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pr_free (
    .req(~valid_q), .found(free_any), .idx(free_idx));

  tlb_lru #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_idx(touch_idx),
    .cand(valid_q & ~wired_q), .victim_found(vic_any), .victim_idx(vic_idx));

  assign lkp_hit  = lkp_valid && hit_any;
  assign lkp_miss = lkp_valid && !hit_any;
  assign lkp_pfn  = lkp_hit ? pfn_q[hit_idx] : '0;

  assign flush_now  = flush || (!asid_en && (cur_asid != prev_asid_q));
  assign fill_ready = !flush_now;
  assign fill_acc   = fill_valid && fill_ready;

  always_comb begin
    src     = SRC_NONE;
    tgt_idx = '0;
    if (fm_any)        begin src = SRC_MATCH; tgt_idx = fm_idx;   end
    else if (free_any) begin src = SRC_FREE;  tgt_idx = free_idx; end
    else if (vic_any)  begin src = SRC_EVICT; tgt_idx = vic_idx;  end
  end

  assign fill_wr   = fill_acc && (src != SRC_NONE);
  assign fill_err  = fill_acc && (src == SRC_NONE);
  assign touch_en  = fill_wr || lkp_hit;
  assign touch_idx = fill_wr ? tgt_idx : hit_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q     <= '0;
      wired_q     <= '0;
      prev_asid_q <= '0;
    end else begin
      prev_asid_q <= cur_asid;
      if (flush_now) begin
        valid_q <= valid_q & wired_q;
      end else if (fill_wr) begin
        valid_q[tgt_idx] <= 1'b1;
        wired_q[tgt_idx] <= fill_wired;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_wr) begin
      vpn_q[tgt_idx]  <= fill_vpn;
      asid_q[tgt_idx] <= cur_asid;
      pfn_q[tgt_idx]  <= fill_pfn;
    end
  end

  // R7, R8: after a flushing cycle no replaceable entry is left valid
  a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush_now |=> ((valid_q & ~wired_q) == '0));

  // R6: the evicted slot is valid and never wired
  a_r6_evict_not_wired: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_wr && src == SRC_EVICT) |-> (valid_q[tgt_idx] && !wired_q[tgt_idx]));

  // R9: a dropped refill only when every slot is valid and wired
  a_r9_err_all_wired: assert property (@(posedge clk) disable iff (!rst_n)
    fill_err |-> ((&valid_q) && (&wired_q)));

  // R4: a written refill sits in its slot on the next cycle
  a_r4_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
    fill_wr |=> (valid_q[$past(tgt_idx)] && vpn_q[$past(tgt_idx)] == $past(fill_vpn)));
endmodule

// File: tb/tlb_asid_cache_tb.sv
module tlb_asid_cache_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        asid_en = 1'b1;
  logic [7:0]  cur_asid = 8'd1;
  logic        flush = 1'b0;
  logic        lkp_valid = 1'b0;
  logic [19:0] lkp_vpn = '0;
  logic        lkp_hit, lkp_miss, fill_ready, fill_err;
  logic [15:0] lkp_pfn;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [15:0] fill_pfn = '0;
  logic        fill_wired = 1'b0;

  int checks = 0;
  int errors = 0;

  // reference model
  bit          mv [N];
  bit          mw [N];
  logic [19:0] mvpn [N];
  logic [7:0]  masid [N];
  logic [15:0] mpfn [N];
  int          mts [N];
  logic [7:0]  mprev = 8'd0;
  int          now = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_asid_cache u_dut (
    .clk(clk), .rst_n(rst_n), .asid_en(asid_en), .cur_asid(cur_asid), .flush(flush),
    .lkp_valid(lkp_valid), .lkp_vpn(lkp_vpn), .lkp_hit(lkp_hit), .lkp_miss(lkp_miss),
    .lkp_pfn(lkp_pfn), .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_wired(fill_wired), .fill_err(fill_err));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                     input string what, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  // compare outputs for the current inputs, then advance the model over one edge
  task automatic step(input string tag);
    int hi, tg;
    bit fl, acc, e_hit;
    #1;
    hi = -1;
    for (int i = 0; i < N; i++)
      if (hi < 0 && mv[i] && mvpn[i] == lkp_vpn && (!asid_en || masid[i] == cur_asid)) hi = i;
    e_hit = lkp_valid && hi >= 0;
    fl  = flush || (!asid_en && cur_asid != mprev);
    acc = fill_valid && !fl;
    tg = -1;
    for (int i = 0; i < N; i++)
      if (tg < 0 && mv[i] && mvpn[i] == fill_vpn && (!asid_en || masid[i] == cur_asid)) tg = i;
    if (tg < 0)
      for (int i = 0; i < N; i++) if (tg < 0 && !mv[i]) tg = i;
    if (tg < 0)
      for (int i = 0; i < N; i++)
        if (mv[i] && !mw[i] && (tg < 0 || mts[i] < mts[tg])) tg = i;
    chk(32'(lkp_hit), 32'(e_hit), "lkp_hit", tag);
    chk(32'(lkp_miss), 32'(lkp_valid && hi < 0), "lkp_miss", tag);
    chk(32'(lkp_pfn), e_hit ? 32'(mpfn[hi]) : 32'd0, "lkp_pfn", tag);
    chk(32'(fill_ready), 32'(!fl), "fill_ready", tag);
    chk(32'(fill_err), 32'(acc && tg < 0), "fill_err", tag);
    @(posedge clk);
    now++;
    mprev = cur_asid;
    if (fl) begin
      for (int i = 0; i < N; i++) if (!mw[i]) mv[i] = 1'b0;
    end
    if (acc && tg >= 0) begin
      mv[tg] = 1'b1; mw[tg] = fill_wired; mvpn[tg] = fill_vpn;
      masid[tg] = cur_asid; mpfn[tg] = fill_pfn; mts[tg] = now;
    end else if (e_hit) begin
      mts[hi] = now;
    end
    @(negedge clk);
  endtask

  task automatic do_fill(input logic [19:0] v, input logic [15:0] p, input bit w,
                         input string tag);
    fill_valid = 1'b1; fill_vpn = v; fill_pfn = p; fill_wired = w;
    step(tag);
    fill_valid = 1'b0; fill_wired = 1'b0;
  endtask

  task automatic do_look(input logic [19:0] v, input string tag);
    lkp_valid = 1'b1; lkp_vpn = v;
    step(tag);
    lkp_valid = 1'b0;
  endtask

  task automatic sweep(input string tag);
    for (int k = 0; k < 4; k++) do_look(20'h100 + 20'(k), tag);
    for (int k = 0; k < 2; k++) do_look(20'h200 + 20'(k), tag);
    for (int k = 0; k < 9; k++) do_look(20'h300 + 20'(k), tag);
    for (int k = 0; k < 6; k++) do_look(20'h500 + 20'(k), tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin mv[i] = 0; mw[i] = 0; mts[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    do_look(20'h005, "R1");
    do_look(20'h000, "R1");

    // R4, R2: fill then hit
    for (int k = 0; k < 4; k++) do_fill(20'h100 + 20'(k), 16'h0010 + 16'(k), 0, "R4");
    for (int k = 0; k < 4; k++) do_look(20'h100 + 20'(k), "R2");
    step("R2");  // idle lookup: both flags low

    // R3: identifier separates entries
    cur_asid = 8'd2; step("R3");
    do_look(20'h100, "R3");
    do_fill(20'h100, 16'h00AA, 0, "R3");
    do_look(20'h100, "R3");
    cur_asid = 8'd1;
    do_look(20'h100, "R3");

    // R4: refill of existing key overwrites
    do_fill(20'h101, 16'h0055, 0, "R4");
    do_look(20'h101, "R4");

    // R6: wired entries, then fill to capacity
    do_fill(20'h200, 16'h0200, 1, "R6");
    do_fill(20'h201, 16'h0201, 1, "R6");
    for (int k = 0; k < 9; k++) do_fill(20'h300 + 20'(k), 16'h0300 + 16'(k), 0, "R4");

    // R5: shape recency, then evict
    do_look(20'h100, "R5");
    do_look(20'h102, "R5");
    for (int k = 0; k < 6; k++) do_fill(20'h500 + 20'(k), 16'h0500 + 16'(k), 0, "R5");
    sweep("R5");
    // R5: refill and hit in the same cycle
    lkp_valid = 1'b1; lkp_vpn = 20'h308;
    do_fill(20'h600, 16'h0600, 0, "R5");
    lkp_valid = 1'b0;
    do_fill(20'h601, 16'h0601, 0, "R5");
    sweep("R6");

    // R7: flush keeps wired entries, refill held off
    flush = 1'b1; fill_valid = 1'b1; fill_vpn = 20'h610; fill_pfn = 16'h0610;
    step("R7");
    flush = 1'b0; fill_valid = 1'b0;
    do_look(20'h200, "R7");
    do_look(20'h610, "R7");
    sweep("R7");

    // R8: checking off, identifier change flushes
    do_fill(20'h700, 16'h0700, 0, "R8");
    asid_en = 1'b0; step("R8");
    cur_asid = 8'd3; fill_valid = 1'b1; fill_vpn = 20'h620; fill_pfn = 16'h0620;
    step("R8");
    fill_valid = 1'b0;
    do_look(20'h700, "R8");
    do_look(20'h201, "R8");
    do_look(20'h620, "R8");
    cur_asid = 8'd1; step("R8");
    asid_en = 1'b1; step("R8");

    // R9: every slot wired, next refill dropped
    for (int k = 0; k < 14; k++) do_fill(20'h800 + 20'(k), 16'h0800 + 16'(k), 1, "R9");
    do_fill(20'h8FF, 16'h08FF, 0, "R9");
    do_look(20'h8FF, "R9");
    do_look(20'h80D, "R9");
    do_fill(20'h805, 16'h0999, 1, "R9");
    do_look(20'h805, "R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule